// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is a single timer channel in waveform mode. It drives two pulse outputs, A and B, from one up-counter, so both share one period. Each output level changes only through programmable set, clear or toggle actions bound to three events. The first is the counter reaching that output's own compare value. The second is the counter wrapping at the period compare value. The third is a software trigger.

A prescaler divides the fast clock, or a slow-tick input can pace the counter instead. Software programs a mode word, three compare values and a command through a simple write port. The software trigger restarts the counter and prescaler and forces the output levels in the same cycle. This gives a deterministic start point and a way to park an output at a fixed level.

Top module: `wave_timer_chan`

## Requirements
- R1: After reset both outputs are low, the counter is zero and counting is stopped. Without a command, the outputs stay low.
- R2: Mode bits [2:0] select the count rate. Values 0, 1, 2 and 3 give one tick every 2, 8, 32 or 128 fast-clock cycles. Value 4 gives one tick per `slow_tick` pulse. Values 5 to 7 give no ticks.
- R3: On each tick the counter increments. On a tick where the counter equals the period compare it returns to 0, and this is the wrap event. The period is therefore (period compare + 1) ticks.
- R4: Write addresses are: 0 mode, 1 compare A, 2 compare B, 3 period compare, 4 command. Mode fields are: A own-compare action [4:3], A wrap action [6:5], A trigger action [8:7], B own-compare action [10:9], B wrap action [12:11], B trigger action [14:13].
- R5: Action codes are 00 none, 01 set, 10 clear and 11 toggle. An output's own-compare event is a tick that moves the counter onto that output's compare value.
- R6: With own action clear, wrap action set and trigger action set, an output is high for C ticks of each period, where C is its compare value.
- R7: With own action set, wrap action clear and trigger action clear, an output is low for C ticks of each period.
- R8: A software trigger overrides both compare events on the same cycle. When a wrap event and an own-compare event coincide, only the wrap action applies.
- R9: A software trigger zeroes the counter and the prescaler and applies the trigger actions on the same edge, whether or not counting is enabled.
- R10: Command bit 0 enables counting and bit 1 disables it; disable wins if both are set. Bit 2 is the software trigger. While counting is disabled, the counter and both outputs hold.
- R11: With all compare actions set to none, an output keeps the level forced by the last software trigger.
- R12: Compare writes take effect on the next cycle without a trigger. The counter width `CNT_W` is a parameter that supports 16 and 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle pulse pacing the counter when rate select is 4 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | max(CNT_W,16) | Register write data |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |

## Verification
A wrong counter or prescaler value shows within one period as a wrong high or low run length on both outputs at once. A wrong action decode or priority shows on the affected output alone. Such an error appears at the first event of the wrong kind, at most (period compare + 1) ticks after a trigger. A trigger that fails to zero the prescaler shifts the first output edge by fewer than one tick. Because of this, the delay from trigger to first edge is measured to the exact cycle.

// File: rtl/wave_timer_chan.sv
module wave_timer_chan #(
  parameter int CNT_W = 16,
  localparam int DW = (CNT_W > 16) ? CNT_W : 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          out_a,
  output logic          out_b
);
  localparam int PRE_W = 7;
  localparam logic [2:0] A_MODE = 3'd0, A_CMPA = 3'd1, A_CMPB = 3'd2, A_PER = 3'd3, A_CMD = 3'd4;

  logic [14:0]      mode_q;
  logic [CNT_W-1:0] ra_q, rb_q, rc_q, cnt_q, cnt_nx;
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic             run_q, cmd, sw, tick, wrap, evt_a, evt_b, pre_mode;
  logic [2:0]       sel;

  function automatic logic act(input logic cur, input logic [1:0] code);
    case (code)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  assign sel = mode_q[2:0];
  assign pre_mode = (sel < 3'd4);

  always_comb begin
    case (sel)
      3'd0:    pre_lim = PRE_W'(1);
      3'd1:    pre_lim = PRE_W'(7);
      3'd2:    pre_lim = PRE_W'(31);
      3'd3:    pre_lim = PRE_W'(127);
      default: pre_lim = '0;
    endcase
  end

  assign cmd    = wr_en && (wr_addr == A_CMD);
  assign sw     = cmd && wr_data[2];
  assign tick   = run_q && ((pre_mode && pre_q == pre_lim) || (sel == 3'd4 && slow_tick));
  assign wrap   = tick && (cnt_q == rc_q);
  assign cnt_nx = wrap ? '0 : cnt_q + 1'b1;
  assign evt_a  = tick && (cnt_nx == ra_q);
  assign evt_b  = tick && (cnt_nx == rb_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
      rc_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE:  mode_q <= wr_data[14:0];
        A_CMPA:  ra_q   <= wr_data[CNT_W-1:0];
        A_CMPB:  rb_q   <= wr_data[CNT_W-1:0];
        A_PER:   rc_q   <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= 1'b0;
    else if (cmd && wr_data[1])
      run_q <= 1'b0;
    else if (cmd && wr_data[0])
      run_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_q <= '0;
    else if (sw)
      pre_q <= '0;
    else if (run_q && pre_mode)
      pre_q <= (pre_q == pre_lim) ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (sw)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else if (sw) begin
      out_a <= act(out_a, mode_q[8:7]);
      out_b <= act(out_b, mode_q[14:13]);
    end else begin
      if (wrap)       out_a <= act(out_a, mode_q[6:5]);
      else if (evt_a) out_a <= act(out_a, mode_q[4:3]);
      if (wrap)       out_b <= act(out_b, mode_q[12:11]);
      else if (evt_b) out_b <= act(out_b, mode_q[10:9]);
    end
  end

  AST_SW_RESTART: assert property (@(posedge clk) disable iff (!rst_n) sw |=> (cnt_q == '0)); // R9
  AST_SW_FORCE_SET_A: assert property (@(posedge clk) disable iff (!rst_n) (sw && mode_q[8:7] == 2'b01) |=> out_a); // R9
  AST_SW_FORCE_CLR_B: assert property (@(posedge clk) disable iff (!rst_n) (sw && mode_q[14:13] == 2'b10) |=> !out_b); // R8
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!run_q && !sw) |=> ($stable(cnt_q) && $stable(out_a) && $stable(out_b))); // R10
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (wrap && !sw) |=> (cnt_q == '0)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) !sw |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1) || cnt_q == '0)); // R3
  AST_IDLE_SEL: assert property (@(posedge clk) disable iff (!rst_n) (sel > 3'd4 && !sw) |=> $stable(cnt_q)); // R2
endmodule

// File: tb/wave_timer_chan_tb.sv
module wave_timer_chan_tb;
  localparam int CNT_W = 16;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic out_a, out_b;
  int errors = 0, checks = 0;
  bit done = 0;

  wave_timer_chan #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_a(out_a), .out_b(out_b));

  always #4 clk = ~clk;

  initial begin
    forever begin
      repeat (4) @(negedge clk);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
    end
  end

  // {sel, RA, RB, RC, inverted, A high, A low, B high, B low}
  localparam logic [79:0] VEC [7] = '{
    {4'd0, 8'd3, 8'd5, 8'd9, 4'd0, 12'd6,   12'd14,  12'd10,  12'd10},
    {4'd1, 8'd2, 8'd1, 8'd4, 4'd0, 12'd16,  12'd24,  12'd8,   12'd32},
    {4'd0, 8'd5, 8'd2, 8'd7, 4'd1, 12'd6,   12'd10,  12'd12,  12'd4},
    {4'd2, 8'd1, 8'd2, 8'd2, 4'd0, 12'd32,  12'd64,  12'd64,  12'd32},
    {4'd3, 8'd1, 8'd1, 8'd1, 4'd1, 12'd128, 12'd128, 12'd128, 12'd128},
    {4'd4, 8'd2, 8'd4, 8'd5, 4'd0, 12'd10,  12'd20,  12'd20,  12'd10},
    {4'd0, 8'd4, 8'd1, 8'd4, 4'd1, 12'd2,   12'd8,   12'd8,   12'd2}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [DW-1:0] mode(input logic [2:0] sel, input logic [1:0] ao, ar, as, bo, br, bs);
    return DW'({bs, br, bo, as, ar, ao, sel});
  endfunction

  function automatic logic pin(input bit b);
    return b ? out_b : out_a;
  endfunction

  task automatic measure(input bit b, output int hi, output int lo);
    int t = 0;
    hi = 0; lo = 0;
    while (pin(b) !== 1'b0 && t < 3000) begin @(negedge clk); t++; end
    while (pin(b) !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
    while (pin(b) === 1'b1 && t < 3000) begin @(negedge clk); t++; hi++; end
    while (pin(b) === 1'b0 && t < 3000) begin @(negedge clk); t++; lo++; end
    if (t >= 3000) begin hi = -1; lo = -1; end
  endtask

  task automatic changes(input int n, output int ch);
    logic pa = out_a, pb = out_b;
    ch = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_a !== pa || out_b !== pb) ch++;
      pa = out_a; pb = out_b;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hi, lo, ch, n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_a after reset", out_a, 0);
    chk("R1 out_b after reset", out_b, 0);
    changes(60, ch);
    chk("R1 idle without command", ch + out_a + out_b, 0);

    for (int v = 0; v < 7; v++) begin
      logic [79:0] e = VEC[v];
      logic inv = e[48];
      wr(3'd4, 16'h0002);
      if (!inv) wr(3'd0, mode(e[78:76], 2'b10, 2'b01, 2'b01, 2'b10, 2'b01, 2'b01));
      else      wr(3'd0, mode(e[78:76], 2'b01, 2'b10, 2'b10, 2'b01, 2'b10, 2'b10));
      wr(3'd1, DW'(e[75:68]));
      wr(3'd2, DW'(e[67:60]));
      wr(3'd3, DW'(e[59:52]));
      wr(3'd4, 16'h0005);
      measure(1'b0, hi, lo);
      chk(inv ? "R7 A high (R2 R3 R4)" : "R6 A high (R2 R3 R4)", hi, int'(e[47:36]));
      chk(inv ? "R7 A low" : "R6 A low", lo, int'(e[35:24]));
      measure(1'b1, hi, lo);
      chk(inv ? "R7 B high (R4 R5)" : "R6 B high (R4 R5)", hi, int'(e[23:12]));
      chk(inv ? "R7 B low" : "R6 B low", lo, int'(e[11:0]));
    end

    // R9: trigger mid-prescale restarts timing exactly
    wr(3'd4, 16'h0002);
    wr(3'd0, mode(3'd1, 2'b10, 2'b01, 2'b01, 2'b10, 2'b01, 2'b01));
    wr(3'd1, 16'd3); wr(3'd2, 16'd3); wr(3'd3, 16'd9);
    wr(3'd4, 16'h0005);
    repeat (13) @(negedge clk);
    wr(3'd4, 16'h0004);
    chk("R9 trigger forces set", out_a, 1);
    n = 0;
    while (out_a === 1'b1 && n < 500) begin n++; @(negedge clk); end
    chk("R9 first edge after trigger", n, 24);

    // R12: compare write without trigger
    wr(3'd1, 16'd6);
    measure(1'b0, hi, lo);
    chk("R12 new compare high", hi, 48);
    chk("R12 new compare low", lo, 32);

    // R10: disable holds, enable resumes
    wr(3'd4, 16'h0003);
    changes(500, ch);
    chk("R10 hold while disabled", ch, 0);
    wr(3'd4, 16'h0001);
    measure(1'b0, hi, lo);
    chk("R10 resume after enable", hi, 48);

    // R11: no compare actions keeps trigger level
    wr(3'd4, 16'h0002);
    wr(3'd0, mode(3'd0, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b10));
    wr(3'd1, 16'd4); wr(3'd2, 16'd4); wr(3'd3, 16'd4);
    wr(3'd4, 16'h0005);
    changes(300, ch);
    chk("R11 no changes", ch, 0);
    chk("R11 A level", out_a, 1);
    chk("R11 B level", out_b, 0);

    // R8: trigger beats wrap, wrap beats own compare
    wr(3'd4, 16'h0002);
    wr(3'd0, mode(3'd0, 2'b10, 2'b01, 2'b10, 2'b10, 2'b01, 2'b10));
    wr(3'd1, 16'd0); wr(3'd2, 16'd0); wr(3'd3, 16'd3);
    wr(3'd4, 16'h0005);
    repeat (7) @(negedge clk);
    wr(3'd4, 16'h0004);
    chk("R8 trigger over wrap", out_a, 0);
    repeat (40) @(negedge clk);
    changes(100, ch);
    chk("R8 wrap over own compare changes", ch, 0);
    chk("R8 wrap over own compare level", out_a, 1);

    // R2: reserved rate select does not count
    wr(3'd4, 16'h0002);
    wr(3'd0, mode(3'd5, 2'b10, 2'b01, 2'b01, 2'b10, 2'b01, 2'b01));
    wr(3'd1, 16'd1); wr(3'd3, 16'd3);
    wr(3'd4, 16'h0005);
    changes(200, ch);
    chk("R2 select 5 idle", ch, 0);
    chk("R2 select 5 level", out_a, 1);

    // R5: toggle on wrap
    wr(3'd4, 16'h0002);
    wr(3'd0, mode(3'd0, 2'b00, 2'b11, 2'b10, 2'b00, 2'b00, 2'b10));
    wr(3'd3, 16'd3);
    wr(3'd4, 16'h0005);
    measure(1'b0, hi, lo);
    chk("R5 toggle high", hi, 8);
    chk("R5 toggle low", lo, 8);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule